// File: doc/BRIEF.md
# Row Read-Merge-Write Array Controller

This controller sits in front of a single-port SRAM array. Each physical row holds one block per cache way, laid side by side. Way `w` occupies row bits `[w*BLK_W +: BLK_W]`. A request names a row and a way. A read returns only that way's block. The array cannot drive its write word line over part of a row, so every write runs in three steps:

- the controller reads the whole row and latches it;
- it replaces the selected block's bytes that the byte mask enables;
- it writes the complete merged row back in one array cycle.

Only one array port exists, so one access is in flight at a time. The request port stays not-ready while a sequence runs. The array is an external synchronous memory with a read latency of one cycle.

Top module: `rmw_row_ctrl`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `arr_re`, `arr_we` and `rsp_valid` are 0.
- R2: A read accepted on clock edge E returns its response at edge E+3. `rsp_valid` is high for exactly that one cycle. `rsp_rdata` carries bits `[way*BLK_W +: BLK_W]` of the addressed row.
- R3: Every accepted request, read or write, drives `arr_re` high for exactly one cycle, the cycle after acceptance, with `arr_addr` equal to the requested row.
- R4: During write-back, every block of `arr_wdata` outside the selected way equals the row that was read just before.
- R5: Inside the selected block, byte `i` (bits `[8i+7:8i]`) takes write-data byte `i` when mask bit `i` is 1 and keeps its latched value otherwise. An all-zero mask writes the row back unchanged.
- R6: Each write produces exactly one `arr_we` cycle, two cycles after its `arr_re` cycle, to the same row, carrying the full row width.
- R7: `req_ready` drops in the cycle after acceptance. For a write it stays low through the write-back cycle. For a read it stays low until the response cycle. It returns to 1 in the cycle after that.
- R8: `arr_re` and `arr_we` are never high in the same cycle.
- R9: A request presented while `req_ready` is 0 is ignored. It causes no array access and changes no row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_AW | Row index |
| req_way | input | WAY_W | Selected way (block within the row) |
| req_wdata | input | BLK_W | Write data for the selected block |
| req_bmask | input | BLK_W/8 | Per-byte write enable within the block |
| rsp_valid | output | 1 | Read response valid (one-cycle pulse) |
| rsp_rdata | output | BLK_W | Read data of the selected block |
| arr_re | output | 1 | Array read enable (full row) |
| arr_we | output | 1 | Array write enable (full row) |
| arr_addr | output | ROW_AW | Array row address |
| arr_wdata | output | WAYS*BLK_W | Full merged row to write |
| arr_rdata | input | WAYS*BLK_W | Full row read data, valid one cycle after `arr_re` |

## Verification
The bench writes to the top way, way 0 and inner ways, using full, sparse and all-zero byte masks. It compares every write-back row against a shadow copy. A merge with a shifted slice or an inverted mask would corrupt neighbouring blocks, and a partial-row write would leave zero or stale bits in the unselected ways; both show up as a mismatch on `arr_wdata`. It samples the per-cycle shape of `req_ready`, `arr_re`, `arr_we` and `rsp_valid` after each acceptance. An early ready, a missing read before write, or overlapping enables all change that pattern. It also holds a request while the controller is busy and then checks the target row. A controller that accepts requests while busy would alter that row.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ROW,
    ST_RESP,
    ST_LATCH,
    ST_WR_ROW
  } rmw_state_t;
endpackage

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic arr_re,
  output logic arr_we,
  output logic rsp_valid,
  output logic accept,
  output logic latch_en,
  output logic resp_en
);
  rmw_state_t state_q;
  logic       wr_q;

  assign accept   = req_valid && req_ready;
  assign latch_en = (state_q == ST_LATCH);
  assign resp_en  = (state_q == ST_RESP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wr_q      <= 1'b0;
      req_ready <= 1'b1;
      arr_re    <= 1'b0;
      arr_we    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            wr_q      <= req_write;
            arr_re    <= 1'b1;
            req_ready <= 1'b0;
            state_q   <= ST_RD_ROW;
          end
        end
        ST_RD_ROW: begin
          arr_re  <= 1'b0;
          state_q <= wr_q ? ST_LATCH : ST_RESP;
        end
        ST_RESP: begin
          rsp_valid <= 1'b1;
          req_ready <= 1'b1;
          state_q   <= ST_IDLE;
        end
        ST_LATCH: begin
          arr_we  <= 1'b1;
          state_q <= ST_WR_ROW;
        end
        ST_WR_ROW: begin
          arr_we    <= 1'b0;
          req_ready <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: no acceptance window outside idle
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> !req_ready);

  // R8: the single port is never asked to read and write at once
  assert_re_we_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(arr_re && arr_we));

  // R3 / R6: a write-back is always preceded by a row read two cycles earlier
  assert_read_before_write_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(arr_we) |-> $past(arr_re, 2));

  // R6: write-back lasts one cycle
  assert_single_write_R6: assert property (@(posedge clk) disable iff (rst)
    arr_we |=> !arr_we);

  // R2: a response follows an array read by two cycles
  assert_resp_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(arr_re, 2));

  // R2: response is a single-cycle pulse
  assert_resp_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/rmw_merge.sv
module rmw_merge #(
  parameter int WAYS  = 4,
  parameter int BLK_W = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int NBYTE = BLK_W / 8,
  localparam int ROW_W = WAYS * BLK_W
) (
  input  logic [ROW_W-1:0] latched_row,
  input  logic [WAY_W-1:0] sel_way,
  input  logic [BLK_W-1:0] new_data,
  input  logic [NBYTE-1:0] byte_en,
  output logic [ROW_W-1:0] merged_row
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      logic take_new;
      assign take_new = (sel_way == WAY_W'(w)) && byte_en[b];
      assign merged_row[w*BLK_W + 8*b +: 8] =
        take_new ? new_data[8*b +: 8] : latched_row[w*BLK_W + 8*b +: 8];
    end
  end
endmodule

// File: rtl/rmw_slice.sv
module rmw_slice #(
  parameter int WAYS  = 4,
  parameter int BLK_W = 32,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int ROW_W = WAYS * BLK_W
) (
  input  logic [ROW_W-1:0] row_in,
  input  logic [WAY_W-1:0] sel_way,
  output logic [BLK_W-1:0] blk_out
);
  always_comb begin
    blk_out = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (sel_way == WAY_W'(w)) blk_out = row_in[w*BLK_W +: BLK_W];
    end
  end
endmodule

// File: rtl/rmw_row_ctrl.sv
module rmw_row_ctrl #(
  parameter int ROWS  = 16,
  parameter int WAYS  = 4,
  parameter int BLK_W = 32,
  localparam int ROW_AW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int NBYTE  = BLK_W / 8,
  localparam int ROW_W  = WAYS * BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_AW-1:0] req_row,
  input  logic [WAY_W-1:0]  req_way,
  input  logic [BLK_W-1:0]  req_wdata,
  input  logic [NBYTE-1:0]  req_bmask,
  output logic              rsp_valid,
  output logic [BLK_W-1:0]  rsp_rdata,
  output logic              arr_re,
  output logic              arr_we,
  output logic [ROW_AW-1:0] arr_addr,
  output logic [ROW_W-1:0]  arr_wdata,
  input  logic [ROW_W-1:0]  arr_rdata
);
  logic              accept, latch_en, resp_en;
  logic [WAY_W-1:0]  way_q;
  logic [BLK_W-1:0]  wdata_q;
  logic [NBYTE-1:0]  mask_q;
  logic [ROW_W-1:0]  latch_q;
  logic [BLK_W-1:0]  slice_blk;

  rmw_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .arr_re    (arr_re),
    .arr_we    (arr_we),
    .rsp_valid (rsp_valid),
    .accept    (accept),
    .latch_en  (latch_en),
    .resp_en   (resp_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_addr  <= '0;
      way_q     <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
      latch_q   <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        arr_addr <= req_row;
        way_q    <= req_way;
        wdata_q  <= req_wdata;
        mask_q   <= req_bmask;
      end
      if (latch_en) latch_q <= arr_rdata;
      if (resp_en)  rsp_rdata <= slice_blk;
    end
  end

  rmw_slice #(.WAYS(WAYS), .BLK_W(BLK_W)) u_slice (
    .row_in  (arr_rdata),
    .sel_way (way_q),
    .blk_out (slice_blk)
  );

  rmw_merge #(.WAYS(WAYS), .BLK_W(BLK_W)) u_merge (
    .latched_row (latch_q),
    .sel_way     (way_q),
    .new_data    (wdata_q),
    .byte_en     (mask_q),
    .merged_row  (arr_wdata)
  );

  // R6: write-back targets the row that was read two cycles before
  assert_wb_same_row_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(arr_we) |-> (arr_addr == $past(arr_addr, 2)));

  // R9: the address cannot move while a sequence is running
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !$rose(arr_re)) |-> $stable(arr_addr));

  // R5: an all-zero byte mask writes back the latched row unchanged
  assert_zero_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (arr_we && (mask_q == '0)) |-> (arr_wdata == latch_q));
endmodule

// File: tb/tb_rmw_row_ctrl.sv
module tb_rmw_row_ctrl;
  localparam int CLK_P = 10;
  localparam int ROWS = 16, WAYS = 4, BLK_W = 32;
  localparam int ROW_W = WAYS * BLK_W;

  typedef struct packed {
    logic        wr;
    logic [3:0]  row;
    logic [1:0]  way;
    logic [31:0] data;
    logic [3:0]  mask;
  } op_t;

  localparam int NVEC = 13;
  localparam op_t VEC [NVEC] = '{
    '{1'b0, 4'd3,  2'd0, 32'h0,         4'h0},
    '{1'b1, 4'd3,  2'd1, 32'hDEADBEEF,  4'hF},
    '{1'b0, 4'd3,  2'd1, 32'h0,         4'h0},
    '{1'b0, 4'd3,  2'd0, 32'h0,         4'h0},
    '{1'b1, 4'd3,  2'd3, 32'h11223344,  4'h5},
    '{1'b0, 4'd3,  2'd3, 32'h0,         4'h0},
    '{1'b1, 4'd7,  2'd0, 32'hFFFFFFFF,  4'h0},
    '{1'b0, 4'd7,  2'd0, 32'h0,         4'h0},
    '{1'b1, 4'd0,  2'd2, 32'hA5A5A5A5,  4'h8},
    '{1'b0, 4'd0,  2'd2, 32'h0,         4'h0},
    '{1'b1, 4'd15, 2'd3, 32'hCAFEF00D,  4'hF},
    '{1'b0, 4'd15, 2'd3, 32'h0,         4'h0},
    '{1'b0, 4'd15, 2'd2, 32'h0,         4'h0}
  };

  logic             clk = 1'b0, rst = 1'b1;
  logic             req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]       req_row = '0;
  logic [1:0]       req_way = '0;
  logic [31:0]      req_wdata = '0;
  logic [3:0]       req_bmask = '0;
  logic             req_ready, rsp_valid, arr_re, arr_we;
  logic [31:0]      rsp_rdata;
  logic [3:0]       arr_addr;
  logic [ROW_W-1:0] arr_wdata, arr_rdata;

  logic [ROW_W-1:0] mem    [ROWS];
  logic [ROW_W-1:0] shadow [ROWS];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rmw_row_ctrl #(.ROWS(ROWS), .WAYS(WAYS), .BLK_W(BLK_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_way(req_way),
    .req_wdata(req_wdata), .req_bmask(req_bmask), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .arr_re(arr_re), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  // external array model: one port, one-cycle read latency
  always @(posedge clk) begin
    if (arr_we) mem[arr_addr] <= arr_wdata;
    if (arr_re) arr_rdata <= mem[arr_addr];
  end

  task automatic check(input bit ok, input string req, input logic [ROW_W-1:0] act,
                       input logic [ROW_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R8: monitored on every cycle
  always @(negedge clk) begin
    if (!rst && arr_re && arr_we) check(1'b0, "R8 re/we overlap", 1, 0);
  end

  function automatic logic [ROW_W-1:0] merge_exp(input logic [ROW_W-1:0] row,
      input logic [1:0] way, input logic [31:0] d, input logic [3:0] m);
    logic [ROW_W-1:0] r = row;
    for (int b = 0; b < 4; b++)
      if (m[b]) r[int'(way)*32 + 8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic run_op(input op_t op);
    logic [5:1] rdy, re, we, rv;
    logic [ROW_W-1:0] wd = '0, exp_row;
    logic [31:0] rd = '0;
    logic [3:0]  ad = '0, rad = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = op.wr; req_row = op.row; req_way = op.way;
    req_wdata = op.data; req_bmask = op.mask;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      rdy[k] = req_ready; re[k] = arr_re; we[k] = arr_we; rv[k] = rsp_valid;
      if (arr_we) begin wd = arr_wdata; ad = arr_addr; end
      if (arr_re) rad = arr_addr;
      if (rsp_valid) rd = rsp_rdata;
    end
    check(re == 5'b00001, "R3 read enable timing", ROW_W'(re), 5'b00001);
    check(rad == op.row, "R3 read row", ROW_W'(rad), ROW_W'(op.row));
    if (op.wr) begin
      exp_row = merge_exp(shadow[op.row], op.way, op.data, op.mask);
      check(rdy == 5'b11000, "R7 ready during write", ROW_W'(rdy), 5'b11000);
      check(we == 5'b00100, "R6 single write-back", ROW_W'(we), 5'b00100);
      check(ad == op.row, "R6 write-back row", ROW_W'(ad), ROW_W'(op.row));
      check(wd == exp_row, "R4/R5 merged row", wd, exp_row);
      check(rv == 5'b0, "R2 no response on write", ROW_W'(rv), 0);
      shadow[op.row] = exp_row;
    end else begin
      check(rdy == 5'b11100, "R7 ready during read", ROW_W'(rdy), 5'b11100);
      check(rv == 5'b00100, "R2 response pulse", ROW_W'(rv), 5'b00100);
      check(rd == shadow[op.row][int'(op.way)*32 +: 32], "R2 read block",
            ROW_W'(rd), ROW_W'(shadow[op.row][int'(op.way)*32 +: 32]));
      check(we == 5'b0, "R8 no write on read", ROW_W'(we), 0);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int w = 0; w < WAYS; w++) begin
        mem[r][w*32 +: 32] = {8'(8'hC0 + w), 8'(8'h10 + r), 8'h5A, 8'(r*4 + w)};
        shadow[r][w*32 +: 32] = {8'(8'hC0 + w), 8'(8'h10 + r), 8'h5A, 8'(r*4 + w)};
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1 ready after reset", ROW_W'(req_ready), 1);
    check({arr_re, arr_we, rsp_valid} == 3'b000, "R1 idle enables",
          ROW_W'({arr_re, arr_we, rsp_valid}), 0);

    for (int i = 0; i < NVEC; i++) run_op(VEC[i]);

    // R9: request held while busy must not be taken
    begin
      op_t first;
      first = '{1'b1, 4'd5, 2'd0, 32'h01020304, 4'hF};
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_row = 4'd5; req_way = 2'd0;
      req_wdata = first.data; req_bmask = 4'hF;
      @(negedge clk);
      req_row = 4'd9; req_wdata = 32'hBADBAD00;   // still valid, controller busy
      for (int k = 2; k <= 3; k++) @(negedge clk);
      req_valid = 1'b0;                           // withdrawn before ready returns
      repeat (3) @(negedge clk);
      shadow[5] = merge_exp(shadow[5], 2'd0, first.data, 4'hF);
      check(mem[9] == shadow[9], "R9 busy request ignored", mem[9], shadow[9]);
      check(mem[5] == shadow[5], "R9 accepted write landed", mem[5], shadow[5]);
      run_op('{1'b0, 4'd9, 2'd0, 32'h0, 4'h0});
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule